// File: doc/BRIEF.md
# Elliptic-Curve Accelerator Register Front End

This block is the register-mapped control and status face of an elliptic-curve arithmetic accelerator. A host reaches it over a plain word-wide bus: a byte address, a write strobe, write data, and read data that follows the address in the same cycle. Behind the bus it keeps a configuration word, the done-interrupt registers, a version word, and six operand windows of 32 bytes each. Three windows hold inputs the host writes: the scalar, input X and input Y. Three hold results the engine returns: result X, Y and Z. The arithmetic engine itself sits outside. It receives a one-cycle launch pulse together with the mode, key length, modulus choice and constant-time request, and it answers with a done pulse, a verification flag and the three result vectors.

A small state machine sequences each command. Its states are IDLE, LAUNCH, BUSY and REJECT. When the start bit is written in IDLE, the machine moves IDLE->LAUNCH if the requested mode code is supported, or IDLE->REJECT if the code is reserved. From LAUNCH it always moves LAUNCH->BUSY, and that cycle carries the launch pulse. A done pulse from the engine moves BUSY->IDLE. REJECT lasts one cycle and moves REJECT->IDLE, raising done with the verification flag cleared. Writing the soft-reset bit returns any state to IDLE and sends an abort pulse to the engine. The start bit reads 1 in every state other than IDLE.

With a short (192-bit) key, only the low 24 bytes of each window are used. The engine sees zeros above bit 191, and result words 6 and 7 read as zero.

Top module: `ecc_accel_csr`

## Requirements
- R1: After reset, the configuration word (0x1C), raw (0x0C), status (0x10) and enable (0x14) all read 0, and the version word at 0xFC reads 37752928.
- R2: Bit 0 of raw is set when a calculation completes, and it stays set until 1 is written to bit 0 of the clear register at 0x18. Status bit 0 and the `irq` output equal raw AND enable bit 0. A done pulse from the engine while the machine is in IDLE does not set raw.
- R3: Writing configuration bit 0 = 1 in IDLE with a supported mode makes `eng_start` high for exactly the one cycle after the write. Configuration bit 0 then reads 1 until the engine's done pulse, after which it reads 0.
- R4: Writing configuration bit 1 = 1 returns the machine to IDLE (bit 0 reads 0) and pulses `eng_abort` for one cycle. Bit 1 always reads 0, and the abort sets no raw bit.
- R5: Configuration bit 2 drives `eng_key256`. When it is 0, bits 255:192 of `eng_k`, `eng_px` and `eng_py` are 0, and result-window words 6 and 7 read 0. When it is 1, all 256 bits pass through.
- R6: Configuration bits 7:4 hold the mode code and drive `eng_mode`. The supported codes are 0 point multiply, 2 verify, 3 verify+multiply, 4 projective multiply, 6 projective verify, 7 verify+projective multiply, 8 modular add, 9 modular subtract, 10 modular multiply and 11 modular divide.
- R7: Configuration bit 3 selects the modulus (0 curve order, 1 field prime). `eng_modp` equals bit 3 only when the mode code is 8 to 11, and is 0 otherwise.
- R8: A start with mode code 1, 5 or 12 to 15 never raises `eng_start`. Instead, done occurs in the next cycle: raw bit 0 is set, configuration bit 0 reads 0 and bit 29 reads 0.
- R9: Configuration bit 29 reads the engine's `eng_verify` value captured at the done pulse.
- R10: While bit 0 reads 1, writes to the operand windows and to configuration bits 7:2 have no effect, and every window read returns 0.
- R11: The windows sit at scalar 0x100, input X 0x120, input Y 0x140, result X 0x160, result Y 0x180 and result Z 0x1A0. Word i of a window holds bits 32i+31:32i. Result windows load from `eng_rx`, `eng_ry` and `eng_rz` at the done pulse.
- R12: Configuration bits 8, 30 and 31 are writable at any time and drive `eng_ctime`, `gate_reg_on` and `gate_mem_on`.
- R13: Bits 27:0 of the version word are writable, and bits 31:28 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 10 | Byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| irq | output | 1 | Masked done interrupt |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_abort | output | 1 | One-cycle abort pulse |
| eng_mode | output | 4 | Mode code |
| eng_key256 | output | 1 | 1 = 256-bit key, 0 = 192-bit key |
| eng_modp | output | 1 | Field-prime modulus for modular modes |
| eng_ctime | output | 1 | Constant-time request |
| gate_reg_on | output | 1 | Force register clock gate on |
| gate_mem_on | output | 1 | Force memory clock gate on |
| eng_k | output | 256 | Scalar operand |
| eng_px | output | 256 | Input X operand |
| eng_py | output | 256 | Input Y operand |
| eng_done | input | 1 | Engine completion pulse |
| eng_verify | input | 1 | Verification result, valid with done |
| eng_rx | input | 256 | Result X |
| eng_ry | input | 256 | Result Y |
| eng_rz | input | 256 | Result Z |

## Verification
A state machine stuck outside IDLE shows up on the very next read: configuration bit 0 stays 1 and every window read returns zero. A state machine that skipped LAUNCH shows up one cycle after the start write, as a missing `eng_start` pulse. A wrong mode decision is visible the cycle after the write, either as a launch pulse for a reserved code or as an immediate done for a supported one. A lost busy guard is visible on the first read after done, as window data or configuration fields that changed while the engine was running. Key-length masking errors appear at once on the upper operand bits and on the read of result word 7.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_BUSY   = 2'd2,
        ST_REJECT = 2'd3
    } seq_state_t;

    localparam int OFS_RAW  = 'h00C;
    localparam int OFS_STAT = 'h010;
    localparam int OFS_ENA  = 'h014;
    localparam int OFS_CLR  = 'h018;
    localparam int OFS_CFG  = 'h01C;
    localparam int OFS_VER  = 'h0FC;

    localparam int B_GO     = 0;
    localparam int B_SRST   = 1;
    localparam int B_KEY    = 2;
    localparam int B_MODP   = 3;
    localparam int B_MODE   = 4;
    localparam int B_CTIME  = 8;
    localparam int B_VERIFY = 29;
    localparam int B_GREG   = 30;
    localparam int B_GMEM   = 31;

    function automatic logic mode_supported(input logic [3:0] m);
        unique case (m)
            4'd0, 4'd2, 4'd3, 4'd4, 4'd6, 4'd7,
            4'd8, 4'd9, 4'd10, 4'd11: return 1'b1;
            default:                   return 1'b0;
        endcase
    endfunction

    function automatic logic mode_modular(input logic [3:0] m);
        return (m >= 4'd8) && (m <= 4'd11);
    endfunction

endpackage

// File: rtl/ecc_csr_seq.sv
module ecc_csr_seq
    import ecc_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       soft_rst,
    input  logic [3:0] req_mode,
    input  logic       eng_done,
    input  logic       eng_verify,
    output logic       busy,
    output logic       eng_start,
    output logic       eng_abort,
    output logic       done_pulse,
    output logic       capture,
    output logic       verify_q
);

    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (start_req) state_d = mode_supported(req_mode) ? ST_LAUNCH : ST_REJECT;
                ST_LAUNCH: state_d = ST_BUSY;
                ST_BUSY:   if (eng_done) state_d = ST_IDLE;
                ST_REJECT: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        eng_start  = 1'b0;
        done_pulse = 1'b0;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LAUNCH: eng_start = 1'b1;
            ST_BUSY: begin
                capture    = eng_done && !soft_rst;
                done_pulse = eng_done && !soft_rst;
            end
            ST_REJECT: done_pulse = !soft_rst;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verify_q  <= 1'b0;
            eng_abort <= 1'b0;
        end else begin
            eng_abort <= soft_rst;
            if (soft_rst)                   verify_q <= 1'b0;
            else if (capture)               verify_q <= eng_verify;
            else if (state_q == ST_REJECT)  verify_q <= 1'b0;
        end
    end

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R8
    reject_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_req && !soft_rst && !mode_supported(req_mode))
        |=> (done_pulse && !eng_start));

    // R4
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && eng_abort));

endmodule

// File: rtl/ecc_csr_irq.sv
module ecc_csr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done_pulse,
    input  logic ena_we,
    input  logic clr_we,
    input  logic wbit0,
    output logic raw_q,
    output logic ena_q,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            ena_q <= 1'b0;
        end else begin
            if (ena_we) ena_q <= wbit0;
            if (done_pulse)           raw_q <= 1'b1;
            else if (clr_we && wbit0) raw_q <= 1'b0;
        end
    end

    assign irq = raw_q & ena_q;

    // R2
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> raw_q);

endmodule

// File: rtl/ecc_csr_opwin.sv
module ecc_csr_opwin #(
    parameter int DATA_W      = 32,
    parameter int WORDS       = 8,
    parameter int SHORT_WORDS = 6,
    parameter int NWIN        = 6,
    parameter int NIN         = 3,
    localparam int IDX_W      = $clog2(WORDS),
    localparam int SEL_W      = $clog2(NWIN),
    localparam int OP_W       = DATA_W * WORDS,
    localparam int SHORT_W    = DATA_W * SHORT_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic              hit,
    input  logic [SEL_W-1:0]  sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              key256,
    input  logic              capture,
    input  logic [OP_W-1:0]   res_x,
    input  logic [OP_W-1:0]   res_y,
    input  logic [OP_W-1:0]   res_z,
    output logic [OP_W-1:0]   op_k,
    output logic [OP_W-1:0]   op_x,
    output logic [OP_W-1:0]   op_y,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [OP_W-1:0] SHORT_MASK = {{(OP_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    logic [OP_W-1:0] win_flat [NWIN];
    logic [OP_W-1:0] res_all  [NWIN-NIN];
    logic [OP_W-1:0] keep_mask;

    assign res_all[0] = res_x;
    assign res_all[1] = res_y;
    assign res_all[2] = res_z;
    assign keep_mask  = key256 ? {OP_W{1'b1}} : SHORT_MASK;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [OP_W-1:0] store;
        if (w < NIN) begin : g_in
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    store <= '0;
                else if (sw_we && hit && !busy && (sel == SEL_W'(w)))
                    store[idx*DATA_W +: DATA_W] <= wdata;
            end
        end else begin : g_res
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       store <= '0;
                else if (capture) store <= res_all[w-NIN] & keep_mask;
            end
        end
        assign win_flat[w] = store;
    end

    assign op_k = win_flat[0] & keep_mask;
    assign op_x = win_flat[1] & keep_mask;
    assign op_y = win_flat[2] & keep_mask;

    always_comb begin
        rdata = '0;
        if (hit && !busy) begin
            for (int w = 0; w < NWIN; w++) begin
                if (sel == SEL_W'(w)) rdata = win_flat[w][idx*DATA_W +: DATA_W];
            end
            if ((sel >= SEL_W'(NIN)) && !key256 && (idx >= IDX_W'(SHORT_WORDS)))
                rdata = '0;
        end
    end

    logic [3*OP_W-1:0] in_cat;
    assign in_cat = {win_flat[2], win_flat[1], win_flat[0]};

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(in_cat));

endmodule

// File: rtl/ecc_accel_csr.sv
module ecc_accel_csr
    import ecc_csr_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int WIN_BYTES   = 32,
    parameter int SHORT_BYTES = 24,
    parameter int WIN_BASE    = 'h100,
    parameter int VER_INIT    = 37752928,
    localparam int NWIN       = 6,
    localparam int WORDS      = WIN_BYTES * 8 / DATA_W,
    localparam int OP_W       = WIN_BYTES * 8,
    localparam int IDX_W      = $clog2(WORDS),
    localparam int SEL_W      = $clog2(NWIN),
    localparam int WIN_SHIFT  = $clog2(WIN_BYTES),
    localparam int WORD_SHIFT = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              eng_start,
    output logic              eng_abort,
    output logic [3:0]        eng_mode,
    output logic              eng_key256,
    output logic              eng_modp,
    output logic              eng_ctime,
    output logic              gate_reg_on,
    output logic              gate_mem_on,
    output logic [OP_W-1:0]   eng_k,
    output logic [OP_W-1:0]   eng_px,
    output logic [OP_W-1:0]   eng_py,
    input  logic              eng_done,
    input  logic              eng_verify,
    input  logic [OP_W-1:0]   eng_rx,
    input  logic [OP_W-1:0]   eng_ry,
    input  logic [OP_W-1:0]   eng_rz
);

    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(OFS_ENA);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(OFS_VER);
    localparam logic [ADDR_W-1:0] A_WLO  = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] A_WHI  = ADDR_W'(WIN_BASE + NWIN * WIN_BYTES);

    logic cfg_we, ena_we, clr_we, ver_we;
    assign cfg_we = reg_we && (reg_addr == A_CFG);
    assign ena_we = reg_we && (reg_addr == A_ENA);
    assign clr_we = reg_we && (reg_addr == A_CLR);
    assign ver_we = reg_we && (reg_addr == A_VER);

    logic              win_hit;
    logic [ADDR_W-1:0] win_off;
    logic [SEL_W-1:0]  win_sel;
    logic [IDX_W-1:0]  win_idx;
    assign win_hit = (reg_addr >= A_WLO) && (reg_addr < A_WHI);
    assign win_off = reg_addr - A_WLO;
    assign win_sel = win_off[WIN_SHIFT +: SEL_W];
    assign win_idx = win_off[WORD_SHIFT +: IDX_W];

    logic busy, done_pulse, capture, verify_q;

    ecc_csr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (cfg_we && reg_wdata[B_GO]),
        .soft_rst   (cfg_we && reg_wdata[B_SRST]),
        .req_mode   (reg_wdata[B_MODE +: 4]),
        .eng_done   (eng_done),
        .eng_verify (eng_verify),
        .busy       (busy),
        .eng_start  (eng_start),
        .eng_abort  (eng_abort),
        .done_pulse (done_pulse),
        .capture    (capture),
        .verify_q   (verify_q)
    );

    logic raw_q, ena_q;

    ecc_csr_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_pulse (done_pulse),
        .ena_we     (ena_we),
        .clr_we     (clr_we),
        .wbit0      (reg_wdata[0]),
        .raw_q      (raw_q),
        .ena_q      (ena_q),
        .irq        (irq)
    );

    logic [DATA_W-1:0] win_rdata;

    ecc_csr_opwin #(
        .DATA_W      (DATA_W),
        .WORDS       (WORDS),
        .SHORT_WORDS (SHORT_BYTES * 8 / DATA_W),
        .NWIN        (NWIN),
        .NIN         (3)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (reg_we),
        .hit     (win_hit),
        .sel     (win_sel),
        .idx     (win_idx),
        .wdata   (reg_wdata),
        .busy    (busy),
        .key256  (eng_key256),
        .capture (capture),
        .res_x   (eng_rx),
        .res_y   (eng_ry),
        .res_z   (eng_rz),
        .op_k    (eng_k),
        .op_x    (eng_px),
        .op_y    (eng_py),
        .rdata   (win_rdata)
    );

    logic [3:0]  mode_q;
    logic        key_q, modp_q, ctime_q, greg_q, gmem_q;
    logic [27:0] ver_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            key_q   <= 1'b0;
            modp_q  <= 1'b0;
            ctime_q <= 1'b0;
            greg_q  <= 1'b0;
            gmem_q  <= 1'b0;
            ver_q   <= 28'(VER_INIT);
        end else begin
            if (cfg_we) begin
                ctime_q <= reg_wdata[B_CTIME];
                greg_q  <= reg_wdata[B_GREG];
                gmem_q  <= reg_wdata[B_GMEM];
                if (!busy) begin
                    key_q  <= reg_wdata[B_KEY];
                    modp_q <= reg_wdata[B_MODP];
                    mode_q <= reg_wdata[B_MODE +: 4];
                end
            end
            if (ver_we) ver_q <= reg_wdata[27:0];
        end
    end

    assign eng_mode    = mode_q;
    assign eng_key256  = key_q;
    assign eng_modp    = modp_q && mode_modular(mode_q);
    assign eng_ctime   = ctime_q;
    assign gate_reg_on = greg_q;
    assign gate_mem_on = gmem_q;

    always_comb begin
        reg_rdata = '0;
        if (win_hit) begin
            reg_rdata = win_rdata;
        end else begin
            unique case (reg_addr)
                A_RAW:  reg_rdata[0] = raw_q;
                A_STAT: reg_rdata[0] = raw_q & ena_q;
                A_ENA:  reg_rdata[0] = ena_q;
                A_CFG: begin
                    reg_rdata[B_GO]         = busy;
                    reg_rdata[B_KEY]        = key_q;
                    reg_rdata[B_MODP]       = modp_q;
                    reg_rdata[B_MODE +: 4]  = mode_q;
                    reg_rdata[B_CTIME]      = ctime_q;
                    reg_rdata[B_VERIFY]     = verify_q;
                    reg_rdata[B_GREG]       = greg_q;
                    reg_rdata[B_GMEM]       = gmem_q;
                end
                A_VER:  reg_rdata[27:0] = ver_q;
                default: reg_rdata = '0;
            endcase
        end
    end

    // R2
    spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !raw_q && !clr_we) |=> !raw_q);

    // R7
    modp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_modp |-> (eng_mode >= 4'd8 && eng_mode <= 4'd11));

endmodule

// File: tb/ecc_accel_csr_bench.sv
module ecc_accel_csr_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [9:0]   reg_addr = '0;
    logic         reg_we = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq, eng_start, eng_abort, eng_key256, eng_modp, eng_ctime;
    logic         gate_reg_on, gate_mem_on;
    logic [3:0]   eng_mode;
    logic [255:0] eng_k, eng_px, eng_py;
    logic         eng_done = 1'b0;
    logic         eng_verify = 1'b0;
    logic [255:0] eng_rx = '0, eng_ry = '0, eng_rz = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ecc_accel_csr u_ecc_accel_csr (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .eng_start(eng_start), .eng_abort(eng_abort), .eng_mode(eng_mode),
        .eng_key256(eng_key256), .eng_modp(eng_modp), .eng_ctime(eng_ctime),
        .gate_reg_on(gate_reg_on), .gate_mem_on(gate_mem_on),
        .eng_k(eng_k), .eng_px(eng_px), .eng_py(eng_py),
        .eng_done(eng_done), .eng_verify(eng_verify),
        .eng_rx(eng_rx), .eng_ry(eng_ry), .eng_rz(eng_rz)
    );

    typedef struct {
        logic [9:0]  addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    event     sample_ev;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares read data against queued expectations
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk($sformatf("%s rd@%h", it.tag, it.addr), reg_rdata, it.exp);
            end
        end
    end

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, logic [31:0] e, string tag);
        rd_item_t it;
        @(negedge clk);
        reg_addr = a;
        #2;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic finish_engine(logic v);
        @(negedge clk);
        eng_done   = 1'b1;
        eng_verify = v;
        @(negedge clk);
        eng_done   = 1'b0;
        eng_verify = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            eng_rx[i*32 +: 32] = 32'hC000_0000 + i;
            eng_ry[i*32 +: 32] = 32'hD000_0000 + i;
            eng_rz[i*32 +: 32] = 32'hE000_0000 + i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(10'h01C, 32'h0, "R1 cfg");
        rd(10'h00C, 32'h0, "R1 raw");
        rd(10'h010, 32'h0, "R1 stat");
        rd(10'h014, 32'h0, "R1 ena");
        rd(10'h0FC, 32'd37752928, "R1 ver");

        for (int i = 0; i < 8; i++) wr(10'h100 + 10'(i*4), 32'hA000_0000 + i);
        wr(10'h120, 32'hB000_0000);
        wr(10'h15C, 32'hB100_0007);
        rd(10'h11C, 32'hA000_0007, "R11 k word7");
        rd(10'h15C, 32'hB100_0007, "R11 py word7");

        wr(10'h014, 32'h1);
        // start, mode 0, 256-bit, constant time, register gate
        wr(10'h01C, 32'h4000_0105);
        chk("R3 start pulse", 32'(eng_start), 32'h1);
        chk("R6 mode", 32'(eng_mode), 32'h0);
        chk("R5 key256", 32'(eng_key256), 32'h1);
        chk("R12 ctime", 32'(eng_ctime), 32'h1);
        chk("R12 greg", 32'(gate_reg_on), 32'h1);
        chk("R5 k upper", eng_k[255:224], 32'hA000_0007);
        rd(10'h01C, 32'h4000_0105, "R3 busy cfg");
        chk("R3 pulse ends", 32'(eng_start), 32'h0);
        wr(10'h100, 32'hFFFF_FFFF);
        wr(10'h01C, 32'h4000_01A0);
        rd(10'h01C, 32'h4000_0105, "R10 cfg frozen");
        rd(10'h104, 32'h0, "R10 busy read");
        chk("R10 k no write", eng_k[31:0], 32'hA000_0000);
        finish_engine(1'b1);
        chk("R2 irq", 32'(irq), 32'h1);
        rd(10'h00C, 32'h1, "R2 raw");
        rd(10'h010, 32'h1, "R2 stat");
        rd(10'h01C, 32'h6000_0104, "R9 verify");
        rd(10'h100, 32'hA000_0000, "R10 window kept");
        rd(10'h17C, 32'hC000_0007, "R11 rx word7");
        rd(10'h1A4, 32'hE000_0001, "R11 rz word1");
        wr(10'h018, 32'h1);
        rd(10'h00C, 32'h0, "R2 clear");
        chk("R2 irq low", 32'(irq), 32'h0);

        wr(10'h014, 32'h0);
        wr(10'h01C, 32'h0000_00A8);
        chk("R6 mode10", 32'(eng_mode), 32'hA);
        chk("R7 modp on", 32'(eng_modp), 32'h1);
        chk("R5 k short", eng_k[223:192], 32'h0);
        chk("R5 k low", eng_k[191:160], 32'hA000_0005);
        rd(10'h17C, 32'h0, "R5 rx word7 short");
        rd(10'h164, 32'hC000_0001, "R5 rx word1 short");
        wr(10'h01C, 32'h0000_0028);
        chk("R7 modp gated", 32'(eng_modp), 32'h0);
        chk("R12 ctime off", 32'(eng_ctime), 32'h0);

        wr(10'h01C, 32'h0000_0011);
        chk("R8 no start", 32'(eng_start), 32'h0);
        rd(10'h00C, 32'h1, "R8 raw");
        rd(10'h01C, 32'h0000_0010, "R8 cfg");
        wr(10'h018, 32'h1);
        wr(10'h01C, 32'h0000_00C1);
        chk("R8 no start 12", 32'(eng_start), 32'h0);
        rd(10'h00C, 32'h1, "R8 raw 12");
        wr(10'h018, 32'h1);

        wr(10'h01C, 32'h0000_0001);
        chk("R3 start m0", 32'(eng_start), 32'h1);
        wr(10'h01C, 32'h0000_0002);
        chk("R4 abort", 32'(eng_abort), 32'h1);
        rd(10'h01C, 32'h0, "R4 idle");
        rd(10'h00C, 32'h0, "R4 no raw");
        finish_engine(1'b1);
        rd(10'h00C, 32'h0, "R2 spurious done");

        wr(10'h0FC, 32'hFFFF_FFFF);
        rd(10'h0FC, 32'h0FFF_FFFF, "R13 ver");
        wr(10'h01C, 32'h8000_0000);
        chk("R12 gmem", 32'(gate_mem_on), 32'h1);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule